// File: doc/BRIEF.md
# In-Order Pipeline Hazard and Flush Controller

This block decides, every cycle, which stages of a five-stage in-order integer pipeline (fetch, decode-1, decode-2 with address generation, execute, write-back) may advance. It looks at the instruction held in each stage and returns hold strobes, bubble-insert strobes and flush strobes. The datapath, register file and caches sit outside the block and only act on these strobes.

Three kinds of work can hold the pipe. The first is extra decode-1 cycles for prefix bytes and two-byte opcodes. The second is an extra decode-2 cycle for complex addressing. The third is a read-modify-write instruction that stays in execute for three phases. A load followed at once by an instruction that needs the loaded register for its address costs a single address-generation interlock cycle. A load whose result is only an ordinary operand goes through with no stall, because that value is forwarded.

Branches are predicted not taken. A taken branch or jump found in execute clears both decode stages and steers fetch to the target in the same cycle, so the penalty is two cycles.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: During reset and in the first cycle after it, every internal cycle counter reads zero. With no stage valid, all hold, bubble and flush outputs are 0 and `exPhase` is 0.
- R2: An instruction in decode-1 stays there for 1 + `d1PrefixCnt` + `d1TwoByte` cycles. In each extra cycle `holdFetch` and `holdD1` are 1 and `bubbleD2` is 1.
- R3: An instruction in decode-2 with `d2ImmDisp` or `d2BaseIdxDisp` set (one or both) spends exactly one extra cycle there. In that cycle `holdFetch`, `holdD1` and `holdD2` are 1 and `bubbleEx` is 1.
- R4: If execute holds a valid load whose `exDestReg` equals a decode-2 base or index register marked valid, the pipe stalls one cycle with the same strobes as R3. A register field whose valid flag is 0 never causes this stall.
- R5: A load in execute whose destination matches no valid decode-2 base or index register causes no hold. A matching register in execute that is not a load also causes no hold.
- R6: The address interlock cycle and the decode-2 extra cycle do not overlap. A load followed by an instruction that both depends on it and needs complex addressing stalls decode-2 for two cycles.
- R7: A read-modify-write instruction stays in execute for three cycles. `exPhase` reads 0 (cache read), then 1 (ALU), then 2 (cache write). In phases 0 and 1, all of `holdFetch`, `holdD1`, `holdD2` and `holdEx` are 1, and `bubbleWb` is 1.
- R8: A register-only or load/store instruction in execute takes one cycle: `holdEx` stays 0 and `exPhase` stays 0.
- R9: A taken branch completing in execute drives `flushD1`, `flushD2` and `redirect` to 1 in that cycle, with `holdFetch` at 0. A branch that is not taken flushes nothing.
- R10: A flush overrides any decode-stage stall in the same cycle. No decode hold or bubble is raised, and the decode-stage cycle counters restart, so the next instruction in decode-1 is timed from zero.
- R11: An execute hold has top priority: `bubbleWb` is raised and not `bubbleEx`. Decode-stage extra work already in progress completes while execute is held.
- R12: A stall in a stage holds every stage upstream of it. Only the stage just downstream of the stalled stage receives a bubble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| d1Valid | input | 1 | Decode-1 holds an instruction |
| d1PrefixCnt | input | PFX_W | Prefix bytes of the decode-1 instruction |
| d1TwoByte | input | 1 | Decode-1 instruction has a two-byte opcode |
| d2Valid | input | 1 | Decode-2 holds an instruction |
| d2ImmDisp | input | 1 | Instruction carries both an immediate and a displacement |
| d2BaseIdxDisp | input | 1 | Address needs base + index + displacement |
| d2BaseValid | input | 1 | Base register field is used |
| d2BaseReg | input | REG_W | Base register number |
| d2IndexValid | input | 1 | Index register field is used |
| d2IndexReg | input | REG_W | Index register number |
| exValid | input | 1 | Execute holds an instruction |
| exIsLoad | input | 1 | Execute instruction is a load |
| exDestReg | input | REG_W | Destination register of the execute instruction |
| exRmw | input | 1 | Execute instruction is register-to-memory read-modify-write |
| exBranchTaken | input | 1 | Execute branch or jump resolved taken |
| holdFetch | output | 1 | Keep the fetch stage |
| holdD1 | output | 1 | Keep decode-1 |
| holdD2 | output | 1 | Keep decode-2 |
| holdEx | output | 1 | Keep execute |
| bubbleD2 | output | 1 | Insert a bubble into decode-2 |
| bubbleEx | output | 1 | Insert a bubble into execute |
| bubbleWb | output | 1 | Insert a bubble into write-back |
| flushD1 | output | 1 | Clear decode-1 |
| flushD2 | output | 1 | Clear decode-2 |
| redirect | output | 1 | Steer fetch to the branch target |
| exPhase | output | PH_W | Read-modify-write phase in execute |

## Verification
The temporal assertions on `exPhase` assume that the instruction attributes at each stage stay constant while that stage is held. They also assume the surrounding pipe never marks a read-modify-write instruction as a taken branch. The directed stimulus follows both rules: it changes a stage's fields only in the cycle after that stage was released, which is how a real pipe would present a new instruction. It also keeps `exRmw` and `exBranchTaken` apart.

// File: rtl/pipe_hazard_pkg.sv
package pipe_hazard_pkg;

  // strobes from the decision logic to the occupancy counters
  typedef struct packed {
    logic d1Step;
    logic d1Clr;
    logic d2Step;
    logic d2Clr;
    logic exStep;
    logic exClr;
  } hzStrobes_t;

  // status returned by the occupancy counters
  typedef struct packed {
    logic d1Done;
    logic d2Done;
    logic exLast;
  } hzStatus_t;

endpackage

// File: rtl/hz_occupancy.sv
module hz_occupancy
  import pipe_hazard_pkg::*;
#(
  parameter int PFX_W      = 3,
  parameter int EX_RMW_CYC = 3,
  parameter int PH_W       = (EX_RMW_CYC > 2) ? $clog2(EX_RMW_CYC) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  hzStrobes_t       strobes,
  input  logic [PFX_W-1:0] d1PrefixCnt,
  input  logic             d1TwoByte,
  input  logic             d2Extra,
  input  logic             exRmw,
  output hzStatus_t        status,
  output logic [PH_W-1:0]  exPhase
);

  localparam int CNT_W = PFX_W + 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(EX_RMW_CYC - 1);

  logic [CNT_W-1:0] d1Cnt;
  logic [CNT_W-1:0] d1Extra;
  logic             d2Cnt;
  logic [PH_W-1:0]  exCnt;

  assign d1Extra = CNT_W'(d1PrefixCnt) + CNT_W'(d1TwoByte);

  always_comb begin
    status.d1Done = (d1Cnt >= d1Extra);
    status.d2Done = !d2Extra || d2Cnt;
    status.exLast = !exRmw || (exCnt == PH_LAST);
  end

  assign exPhase = exCnt;

  // decode-1 extra cycle counter, saturating at the needed count
  always_ff @(posedge clk) begin
    if (!rstN)                                 d1Cnt <= '0;
    else if (strobes.d1Clr)                    d1Cnt <= '0;
    else if (strobes.d1Step && !status.d1Done) d1Cnt <= d1Cnt + 1'b1;
  end

  // decode-2 extra cycle flag
  always_ff @(posedge clk) begin
    if (!rstN)                                 d2Cnt <= 1'b0;
    else if (strobes.d2Clr)                    d2Cnt <= 1'b0;
    else if (strobes.d2Step && !status.d2Done) d2Cnt <= 1'b1;
  end

  // execute read-modify-write phase counter
  always_ff @(posedge clk) begin
    if (!rstN)                                 exCnt <= '0;
    else if (strobes.exClr)                    exCnt <= '0;
    else if (strobes.exStep && !status.exLast) exCnt <= exCnt + 1'b1;
  end

endmodule

// File: rtl/hz_decide.sv
module hz_decide
  import pipe_hazard_pkg::*;
#(
  parameter int REG_W = 3
) (
  input  logic             d1Valid,
  input  logic             d2Valid,
  input  logic             d2BaseValid,
  input  logic [REG_W-1:0] d2BaseReg,
  input  logic             d2IndexValid,
  input  logic [REG_W-1:0] d2IndexReg,
  input  logic             exValid,
  input  logic             exIsLoad,
  input  logic [REG_W-1:0] exDestReg,
  input  logic             exBranchTaken,
  input  hzStatus_t        status,
  output logic             holdFetch,
  output logic             holdD1,
  output logic             holdD2,
  output logic             holdEx,
  output logic             bubbleD2,
  output logic             bubbleEx,
  output logic             bubbleWb,
  output logic             flushD1,
  output logic             flushD2,
  output logic             redirect,
  output hzStrobes_t       strobes
);

  logic exBusy, takenNow, agiHit, d2Stall, d1Stall;
  logic baseHit, indexHit;

  always_comb begin
    baseHit  = d2BaseValid  && (d2BaseReg  == exDestReg);
    indexHit = d2IndexValid && (d2IndexReg == exDestReg);
    agiHit   = exValid && exIsLoad && d2Valid && (baseHit || indexHit);

    exBusy   = exValid && !status.exLast;
    takenNow = exValid && exBranchTaken && !exBusy;
    d2Stall  = d2Valid && (agiHit || !status.d2Done);
    d1Stall  = d1Valid && !status.d1Done;

    // priority: execute busy, then flush, then decode-2, then decode-1
    holdEx    = exBusy;
    holdD2    = exBusy || (!takenNow && d2Stall);
    holdD1    = holdD2 || (!takenNow && d1Stall);
    holdFetch = holdD1;

    bubbleWb  = exBusy;
    bubbleEx  = !exBusy && !takenNow && d2Stall;
    bubbleD2  = !holdD2 && !takenNow && d1Stall;

    flushD1   = takenNow;
    flushD2   = takenNow;
    redirect  = takenNow;

    strobes.d1Step = d1Valid && holdD1;
    strobes.d1Clr  = !d1Valid || !holdD1 || takenNow;
    strobes.d2Step = d2Valid && holdD2 && !agiHit;
    strobes.d2Clr  = !d2Valid || !holdD2 || takenNow;
    strobes.exStep = exValid && holdEx;
    strobes.exClr  = !exValid || !holdEx;
  end

endmodule

// File: rtl/pipe_hazard_ctrl.sv
module pipe_hazard_ctrl
  import pipe_hazard_pkg::*;
#(
  parameter int PFX_W      = 3,
  parameter int REG_W      = 3,
  parameter int EX_RMW_CYC = 3,
  parameter int PH_W       = (EX_RMW_CYC > 2) ? $clog2(EX_RMW_CYC) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             d1Valid,
  input  logic [PFX_W-1:0] d1PrefixCnt,
  input  logic             d1TwoByte,
  input  logic             d2Valid,
  input  logic             d2ImmDisp,
  input  logic             d2BaseIdxDisp,
  input  logic             d2BaseValid,
  input  logic [REG_W-1:0] d2BaseReg,
  input  logic             d2IndexValid,
  input  logic [REG_W-1:0] d2IndexReg,
  input  logic             exValid,
  input  logic             exIsLoad,
  input  logic [REG_W-1:0] exDestReg,
  input  logic             exRmw,
  input  logic             exBranchTaken,
  output logic             holdFetch,
  output logic             holdD1,
  output logic             holdD2,
  output logic             holdEx,
  output logic             bubbleD2,
  output logic             bubbleEx,
  output logic             bubbleWb,
  output logic             flushD1,
  output logic             flushD2,
  output logic             redirect,
  output logic [PH_W-1:0]  exPhase
);

  hzStrobes_t strobes;
  hzStatus_t  status;

  hz_occupancy #(
    .PFX_W(PFX_W), .EX_RMW_CYC(EX_RMW_CYC), .PH_W(PH_W)
  ) i_occupancy (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .d1PrefixCnt(d1PrefixCnt),
    .d1TwoByte  (d1TwoByte),
    .d2Extra    (d2ImmDisp || d2BaseIdxDisp),
    .exRmw      (exRmw),
    .status     (status),
    .exPhase    (exPhase)
  );

  hz_decide #(.REG_W(REG_W)) i_decide (
    .d1Valid      (d1Valid),
    .d2Valid      (d2Valid),
    .d2BaseValid  (d2BaseValid),
    .d2BaseReg    (d2BaseReg),
    .d2IndexValid (d2IndexValid),
    .d2IndexReg   (d2IndexReg),
    .exValid      (exValid),
    .exIsLoad     (exIsLoad),
    .exDestReg    (exDestReg),
    .exBranchTaken(exBranchTaken),
    .status       (status),
    .holdFetch    (holdFetch),
    .holdD1       (holdD1),
    .holdD2       (holdD2),
    .holdEx       (holdEx),
    .bubbleD2     (bubbleD2),
    .bubbleEx     (bubbleEx),
    .bubbleWb     (bubbleWb),
    .flushD1      (flushD1),
    .flushD2      (flushD2),
    .redirect     (redirect),
    .strobes      (strobes)
  );

endmodule

// File: rtl/pipe_hazard_ctrl_chk.sv
module pipe_hazard_ctrl_chk #(
  parameter int EX_RMW_CYC = 3,
  parameter int PH_W       = 2
) (
  input logic            clk,
  input logic            rstN,
  input logic            holdFetch,
  input logic            holdD1,
  input logic            holdD2,
  input logic            holdEx,
  input logic            bubbleD2,
  input logic            bubbleEx,
  input logic            bubbleWb,
  input logic            flushD1,
  input logic            flushD2,
  input logic            redirect,
  input logic [PH_W-1:0] exPhase
);

  localparam logic [PH_W-1:0] PH_LAST = PH_W'(EX_RMW_CYC - 1);

  assert_hold_chain_R12: assert property (@(posedge clk) disable iff (!rstN)
    holdD2 |-> (holdD1 && holdFetch));

  assert_d1_bubble_R2: assert property (@(posedge clk) disable iff (!rstN)
    (holdD1 && !holdD2) |-> (bubbleD2 && !bubbleEx));

  assert_flush_set_R9: assert property (@(posedge clk) disable iff (!rstN)
    flushD1 |-> (flushD2 && redirect && !holdFetch && !holdEx));

  assert_no_decode_hold_on_flush_R10: assert property (@(posedge clk) disable iff (!rstN)
    redirect |-> (!holdD1 && !holdD2 && !bubbleD2 && !bubbleEx));

  assert_ex_priority_R11: assert property (@(posedge clk) disable iff (!rstN)
    holdEx |-> (bubbleWb && !bubbleEx && !redirect && holdD2));

  assert_phase_advance_R7: assert property (@(posedge clk) disable iff (!rstN)
    (holdEx && exPhase == '0) |=> (exPhase == PH_W'(1)));

  assert_phase_wrap_R7: assert property (@(posedge clk) disable iff (!rstN)
    (exPhase == PH_LAST) |=> (exPhase == '0));

  assert_phase_range_R7: assert property (@(posedge clk) disable iff (!rstN)
    exPhase <= PH_LAST);

endmodule

bind pipe_hazard_ctrl pipe_hazard_ctrl_chk #(.EX_RMW_CYC(EX_RMW_CYC), .PH_W(PH_W)) i_chk (
  .clk(clk), .rstN(rstN),
  .holdFetch(holdFetch), .holdD1(holdD1), .holdD2(holdD2), .holdEx(holdEx),
  .bubbleD2(bubbleD2), .bubbleEx(bubbleEx), .bubbleWb(bubbleWb),
  .flushD1(flushD1), .flushD2(flushD2), .redirect(redirect),
  .exPhase(exPhase)
);

// File: tb/test_pipe_hazard_ctrl.sv
`timescale 1ns/1ps
module test_pipe_hazard_ctrl;

  localparam int PFX_W = 3;
  localparam int REG_W = 3;
  localparam int PH_W  = 2;

  // output vector bit order: hF hD1 hD2 hEx bD2 bEx bWb fD1 fD2 redir
  localparam logic [9:0] NONE    = 10'b0000000000;
  localparam logic [9:0] D1STALL = 10'b1100100000;
  localparam logic [9:0] D2STALL = 10'b1110010000;
  localparam logic [9:0] EXSTALL = 10'b1111001000;
  localparam logic [9:0] FLUSH   = 10'b0000000111;

  logic clk = 1'b0;
  logic rstN;
  logic d1Valid, d1TwoByte, d2Valid, d2ImmDisp, d2BaseIdxDisp;
  logic d2BaseValid, d2IndexValid, exValid, exIsLoad, exRmw, exBranchTaken;
  logic [PFX_W-1:0] d1PrefixCnt;
  logic [REG_W-1:0] d2BaseReg, d2IndexReg, exDestReg;
  logic holdFetch, holdD1, holdD2, holdEx, bubbleD2, bubbleEx, bubbleWb;
  logic flushD1, flushD2, redirect;
  logic [PH_W-1:0] exPhase;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  pipe_hazard_ctrl i_pipe_hazard_ctrl (.*);

  task automatic clearInputs();
    d1Valid = 0; d1PrefixCnt = '0; d1TwoByte = 0;
    d2Valid = 0; d2ImmDisp = 0; d2BaseIdxDisp = 0;
    d2BaseValid = 0; d2BaseReg = '0; d2IndexValid = 0; d2IndexReg = '0;
    exValid = 0; exIsLoad = 0; exDestReg = '0; exRmw = 0; exBranchTaken = 0;
  endtask

  // check at the falling edge, then move to just after the next rising edge
  task automatic cyc(input string req, input logic [9:0] expV, input logic [PH_W-1:0] expPh);
    logic [9:0] act;
    @(negedge clk);
    act = {holdFetch, holdD1, holdD2, holdEx, bubbleD2, bubbleEx, bubbleWb,
           flushD1, flushD2, redirect};
    nChecks++;
    if (act !== expV || exPhase !== expPh) begin
      nFails++;
      $display("FAIL %s: strobes=%b phase=%0d expected strobes=%b phase=%0d",
               req, act, exPhase, expV, expPh);
    end
    @(posedge clk); #1;
  endtask

  task automatic tReset();  // R1
    clearInputs();
    rstN = 0;
    exValid = 1; exRmw = 1;
    repeat (3) @(posedge clk);
    #1;
    cyc("R1 phase in reset", EXSTALL, 2'd0);
    rstN = 1;
    cyc("R1 first cycle after reset", EXSTALL, 2'd0);
    cyc("R1 counter moves", EXSTALL, 2'd1);
    cyc("R1 rmw end", NONE, 2'd2);
    clearInputs();
    cyc("R1 idle outputs", NONE, 2'd0);
  endtask

  task automatic tDecode1();  // R2, R12
    clearInputs();
    d1Valid = 1; d1PrefixCnt = 3'd2; d1TwoByte = 1;
    cyc("R2 extra 1", D1STALL, 2'd0);
    cyc("R2 extra 2", D1STALL, 2'd0);
    cyc("R12 extra 3", D1STALL, 2'd0);
    cyc("R2 done", NONE, 2'd0);
    d1PrefixCnt = 3'd0; d1TwoByte = 0;
    cyc("R2 plain one cycle", NONE, 2'd0);
  endtask

  task automatic tDecode2();  // R3
    clearInputs();
    d2Valid = 1; d2ImmDisp = 1; d2BaseIdxDisp = 1;
    cyc("R3 both flags one extra", D2STALL, 2'd0);
    cyc("R3 done", NONE, 2'd0);
    d2ImmDisp = 0;
    cyc("R3 base+index+disp extra", D2STALL, 2'd0);
    cyc("R3 done again", NONE, 2'd0);
  endtask

  task automatic tInterlock();  // R4
    clearInputs();
    exValid = 1; exIsLoad = 1; exDestReg = 3'd5;
    d2Valid = 1; d2BaseValid = 0; d2BaseReg = 3'd5;
    d2IndexValid = 1; d2IndexReg = 3'd5;
    cyc("R4 index match stall", D2STALL, 2'd0);
    exValid = 0;
    cyc("R4 single cycle", NONE, 2'd0);
    exValid = 1; d2IndexReg = 3'd3;
    cyc("R4 invalid base field ignored", NONE, 2'd0);
    d2BaseValid = 1; d2IndexValid = 0;
    cyc("R4 base match stall", D2STALL, 2'd0);
  endtask

  task automatic tForward();  // R5
    clearInputs();
    exValid = 1; exIsLoad = 1; exDestReg = 3'd5;
    d2Valid = 1; d2BaseValid = 1; d2BaseReg = 3'd2;
    d2IndexValid = 1; d2IndexReg = 3'd3;
    cyc("R5 load no address use", NONE, 2'd0);
    exIsLoad = 0; exDestReg = 3'd2;
    cyc("R5 non-load match", NONE, 2'd0);
  endtask

  task automatic tSerial();  // R6
    clearInputs();
    exValid = 1; exIsLoad = 1; exDestReg = 3'd4;
    d2Valid = 1; d2ImmDisp = 1; d2BaseValid = 1; d2BaseReg = 3'd4;
    cyc("R6 interlock cycle", D2STALL, 2'd0);
    exValid = 0;
    cyc("R6 address extra cycle", D2STALL, 2'd0);
    cyc("R6 released", NONE, 2'd0);
  endtask

  task automatic tRmw();  // R7, R8
    clearInputs();
    exValid = 1; exRmw = 1;
    cyc("R7 read phase", EXSTALL, 2'd0);
    cyc("R7 alu phase", EXSTALL, 2'd1);
    cyc("R7 write phase", NONE, 2'd2);
    exRmw = 0; exIsLoad = 1;
    cyc("R8 load one cycle", NONE, 2'd0);
    exIsLoad = 0;
    cyc("R8 alu one cycle", NONE, 2'd0);
  endtask

  task automatic tBranch();  // R9
    clearInputs();
    d1Valid = 1; d2Valid = 1; exValid = 1; exBranchTaken = 1;
    cyc("R9 taken flush", FLUSH, 2'd0);
    exBranchTaken = 0;
    cyc("R9 not taken", NONE, 2'd0);
  endtask

  task automatic tFlushOverStall();  // R10
    clearInputs();
    d1Valid = 1; d1PrefixCnt = 3'd2;
    cyc("R10 pre stall", D1STALL, 2'd0);
    d2Valid = 1; d2ImmDisp = 1; exValid = 1; exBranchTaken = 1;
    cyc("R10 flush wins", FLUSH, 2'd0);
    d2Valid = 0; d2ImmDisp = 0; exValid = 0; exBranchTaken = 0;
    cyc("R10 restart 1", D1STALL, 2'd0);
    cyc("R10 restart 2", D1STALL, 2'd0);
    cyc("R10 restart done", NONE, 2'd0);
  endtask

  task automatic tPriority();  // R11
    clearInputs();
    exValid = 1; exRmw = 1;
    d2Valid = 1; d2ImmDisp = 1;
    d1Valid = 1; d1PrefixCnt = 3'd1;
    cyc("R11 ex hold first", EXSTALL, 2'd0);
    cyc("R11 ex hold second", EXSTALL, 2'd1);
    cyc("R11 decode work overlapped", NONE, 2'd2);
  endtask

  initial begin
    tReset();
    tDecode1();
    tDecode2();
    tInterlock();
    tForward();
    tSerial();
    tRmw();
    tBranch();
    tFlushOverStall();
    tPriority();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run hung, actual=timeout expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule